// File: doc/BRIEF.md
# Torus Route Selector

This block makes the routing decision for one node of a three-dimensional torus network. For each packet header it works out which way is shorter in each of the X, Y and Z rings, counting the wraparound links. It then picks one of six output links (plus and minus in each dimension) and one of four virtual channels, using the free-credit count that each downstream link and channel reports.

Ordinary packets travel adaptively on the two dynamic channels of any link that shortens the remaining distance. When neither dynamic channel on any such link can hold a whole packet, the block falls back to a dimension-ordered escape channel. Packets marked as priority use only the priority channel, and only on the dimension-ordered link. A channel is granted only when it has room for a complete packet. A header addressed to the node itself gets a local-delivery grant. When no legal choice exists the header is held off, and the decision is tried again on the next cycle.

The header is taken in under a valid/ready handshake. The decision comes out of a registered grant stage one cycle later, and that stage holds its value until the consumer accepts it.

Top module: `torus_route_sel`

## Requirements
- R1: After reset, `gnt_valid` is 0 until a header has been accepted.
- R2: In each dimension the forward distance is (destination − own coordinate) mod ring size. A distance of 0 needs no hop. A distance of at most half the ring means plus; any larger distance means minus. Link codes are 0 = X+, 1 = X−, 2 = Y+, 3 = Y−, 4 = Z+, 5 = Z−.
- R3: When the destination equals the node's own coordinates, the grant has `gnt_local` = 1, `gnt_port` = 0 and `gnt_vc` = 0, whatever the credits are.
- R4: A non-priority header is granted a dynamic channel (`gnt_vc` 0 or 1) only on a link that R2 marks as minimal, and only when that channel's credit is at least `PKT`.
- R5: Among the eligible dynamic choices, the one with the largest credit wins. On equal credit, X beats Y and Y beats Z; within one link, channel 0 beats channel 1.
- R6: When no dynamic choice is eligible, a non-priority header gets channel 2 on the dimension-ordered link: the first of X, Y, Z that has a nonzero distance. This happens only if channel 2 there has at least `PKT` credits.
- R7: A priority header gets only channel 3, on the dimension-ordered link, and only when that channel has at least `PKT` credits.
- R8: When no legal choice exists, `hdr_ready` is 0 and no grant is produced.
- R9: A header accepted at a clock edge appears as `gnt_valid` = 1, with its decision, right after that edge.
- R10: While `gnt_valid` = 1 and `gnt_ready` = 0, the grant holds steady and `hdr_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| node_x | input | XW | Own X coordinate |
| node_y | input | YW | Own Y coordinate |
| node_z | input | ZW | Own Z coordinate |
| dest_x | input | XW | Header destination X |
| dest_y | input | YW | Header destination Y |
| dest_z | input | ZW | Header destination Z |
| hdr_prio | input | 1 | Header priority flag |
| hdr_valid | input | 1 | Header present |
| hdr_ready | output | 1 | Header accepted this cycle when valid |
| credit_lvl | input | 24*CW | Free credits; link p, channel v at bits [(p*4+v)*CW +: CW] |
| gnt_valid | output | 1 | Grant present |
| gnt_local | output | 1 | Deliver to this node |
| gnt_port | output | 3 | Granted link code |
| gnt_vc | output | 2 | Granted channel: 0/1 dynamic, 2 escape, 3 priority |
| gnt_ready | input | 1 | Consumer takes the grant |

## Verification
On a 4x4x4 torus, every pairing of own and destination coordinates is swept, with and without the priority flag. Each sweep runs under five credit patterns. With all credits full, every pick is a tie, so the grant shows only the direction and tie-break order. Varied credits separate the largest-credit choice from the tie-break. Starving the dynamic channels forces the escape path, and starving escape as well exposes stalls. All-zero credits check that local delivery never depends on credit. A separate backpressure sequence checks that the grant is held.

// File: rtl/torus_pkg.sv
package torus_pkg;
    localparam int NPORT  = 6;
    localparam int NVC    = 4;
    localparam int NDIM   = 3;
    localparam int VC_ESC = 2;
    localparam int VC_PRI = 3;

    typedef enum logic [1:0] {
        DIR_NONE  = 2'd0,
        DIR_PLUS  = 2'd1,
        DIR_MINUS = 2'd2
    } dir_e;

    typedef struct packed {
        logic       valid;
        logic       at_home;
        logic [2:0] port;
        logic [1:0] vc;
    } grant_t;
endpackage

// File: rtl/torus_dim_dir.sv
module torus_dim_dir
    import torus_pkg::*;
#(
    parameter int W = 6
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] dst,
    output dir_e         dir
);
    localparam logic [W-1:0] HALF = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] fwd;

    always_comb begin
        fwd = dst - cur;
        if (fwd == '0)
            dir = DIR_NONE;
        else if (fwd <= HALF)
            dir = DIR_PLUS;
        else
            dir = DIR_MINUS;
    end
endmodule

// File: rtl/torus_adapt_pick.sv
module torus_adapt_pick
    import torus_pkg::*;
#(
    parameter int CW  = 4,
    parameter int PKT = 8
) (
    input  logic [NPORT-1:0]        cand,
    input  logic [NPORT*NVC*CW-1:0] credit_lvl,
    output logic                    found,
    output logic [2:0]              best_port,
    output logic                    best_vc
);
    logic [CW-1:0] best_cr;

    always_comb begin
        found     = 1'b0;
        best_port = 3'd0;
        best_vc   = 1'b0;
        best_cr   = '0;
        for (int p = 0; p < NPORT; p++) begin
            for (int v = 0; v < 2; v++) begin
                if (cand[p] && credit_lvl[(p*NVC+v)*CW +: CW] >= CW'(PKT) &&
                    (!found || credit_lvl[(p*NVC+v)*CW +: CW] > best_cr)) begin
                    found     = 1'b1;
                    best_port = 3'(p);
                    best_vc   = 1'(v);
                    best_cr   = credit_lvl[(p*NVC+v)*CW +: CW];
                end
            end
        end
    end
endmodule

// File: rtl/torus_route_sel.sv
module torus_route_sel
    import torus_pkg::*;
#(
    parameter int XW  = 6,
    parameter int YW  = 5,
    parameter int ZW  = 5,
    parameter int CW  = 4,
    parameter int PKT = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [XW-1:0]           node_x,
    input  logic [YW-1:0]           node_y,
    input  logic [ZW-1:0]           node_z,
    input  logic [XW-1:0]           dest_x,
    input  logic [YW-1:0]           dest_y,
    input  logic [ZW-1:0]           dest_z,
    input  logic                    hdr_prio,
    input  logic                    hdr_valid,
    output logic                    hdr_ready,
    input  logic [NPORT*NVC*CW-1:0] credit_lvl,
    output logic                    gnt_valid,
    output logic                    gnt_local,
    output logic [2:0]              gnt_port,
    output logic [1:0]              gnt_vc,
    input  logic                    gnt_ready
);
    dir_e             dirs [NDIM];
    logic [NPORT-1:0] cand;
    logic             at_home;
    logic [2:0]       dor_port;
    logic             ad_found;
    logic [2:0]       ad_port;
    logic             ad_vc;
    logic [CW-1:0]    esc_cr;
    logic [CW-1:0]    pri_cr;
    logic             can_go;
    grant_t           pick;
    grant_t           gnt_d, gnt_q;

    torus_dim_dir #(.W(XW)) u_dir_x (.cur(node_x), .dst(dest_x), .dir(dirs[0]));
    torus_dim_dir #(.W(YW)) u_dir_y (.cur(node_y), .dst(dest_y), .dir(dirs[1]));
    torus_dim_dir #(.W(ZW)) u_dir_z (.cur(node_z), .dst(dest_z), .dir(dirs[2]));

    for (genvar d = 0; d < NDIM; d++) begin : g_cand
        assign cand[2*d]   = (dirs[d] == DIR_PLUS);
        assign cand[2*d+1] = (dirs[d] == DIR_MINUS);
    end

    always_comb begin
        dor_port = 3'd0;
        for (int d = NDIM-1; d >= 0; d--) begin
            if (dirs[d] != DIR_NONE)
                dor_port = 3'(2*d + ((dirs[d] == DIR_MINUS) ? 1 : 0));
        end
    end

    assign at_home = (cand == '0);
    assign esc_cr  = credit_lvl[(int'(dor_port)*NVC + VC_ESC)*CW +: CW];
    assign pri_cr  = credit_lvl[(int'(dor_port)*NVC + VC_PRI)*CW +: CW];

    torus_adapt_pick #(.CW(CW), .PKT(PKT)) u_pick (
        .cand      (cand),
        .credit_lvl(credit_lvl),
        .found     (ad_found),
        .best_port (ad_port),
        .best_vc   (ad_vc)
    );

    always_comb begin
        pick   = '0;
        can_go = 1'b0;
        if (at_home) begin
            can_go       = 1'b1;
            pick.at_home = 1'b1;
        end else if (hdr_prio) begin
            if (pri_cr >= CW'(PKT)) begin
                can_go    = 1'b1;
                pick.port = dor_port;
                pick.vc   = 2'(VC_PRI);
            end
        end else if (ad_found) begin
            can_go    = 1'b1;
            pick.port = ad_port;
            pick.vc   = {1'b0, ad_vc};
        end else if (esc_cr >= CW'(PKT)) begin
            can_go    = 1'b1;
            pick.port = dor_port;
            pick.vc   = 2'(VC_ESC);
        end

        hdr_ready = (!gnt_q.valid || gnt_ready) && can_go;

        gnt_d = gnt_q;
        if (gnt_ready)
            gnt_d.valid = 1'b0;
        if (hdr_valid && hdr_ready) begin
            gnt_d       = pick;
            gnt_d.valid = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            gnt_q <= '0;
        else
            gnt_q <= gnt_d;
    end

    assign gnt_valid = gnt_q.valid;
    assign gnt_local = gnt_q.at_home;
    assign gnt_port  = gnt_q.port;
    assign gnt_vc    = gnt_q.vc;

    // R9
    accept_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && hdr_ready) |=> gnt_valid);

    // R10
    hold_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid && !gnt_ready) |=> (gnt_valid && $stable(gnt_port) &&
                                       $stable(gnt_vc) && $stable(gnt_local)));

    // R10
    block_hdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid && !gnt_ready) |-> !hdr_ready);

    // R7
    prio_vc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && hdr_ready && hdr_prio && !at_home) |=> (gnt_vc == 2'(VC_PRI)));

    // R3
    home_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && hdr_ready && node_x == dest_x && node_y == dest_y &&
         node_z == dest_z) |=> gnt_local);

    // R4
    adapt_credit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && hdr_ready && !hdr_prio && ad_found && !at_home) |=>
        (gnt_vc[1] == 1'b0 && !gnt_local));
endmodule

// File: tb/torus_route_sel_tb_top.sv
module torus_route_sel_tb_top;
    localparam int W   = 2;
    localparam int CW  = 3;
    localparam int PKT = 4;
    localparam int RING = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [W-1:0] node_x = '0, node_y = '0, node_z = '0;
    logic [W-1:0] dest_x = '0, dest_y = '0, dest_z = '0;
    logic hdr_prio = 1'b0, hdr_valid = 1'b0, gnt_ready = 1'b1;
    logic [6*4*CW-1:0] credit_lvl = '0;
    logic hdr_ready, gnt_valid, gnt_local;
    logic [2:0] gnt_port;
    logic [1:0] gnt_vc;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int crv [6][4];

    always #2 clk = ~clk;

    torus_route_sel #(.XW(W), .YW(W), .ZW(W), .CW(CW), .PKT(PKT)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .node_x(node_x), .node_y(node_y), .node_z(node_z),
        .dest_x(dest_x), .dest_y(dest_y), .dest_z(dest_z),
        .hdr_prio(hdr_prio), .hdr_valid(hdr_valid), .hdr_ready(hdr_ready),
        .credit_lvl(credit_lvl),
        .gnt_valid(gnt_valid), .gnt_local(gnt_local),
        .gnt_port(gnt_port), .gnt_vc(gnt_vc), .gnt_ready(gnt_ready)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int cr_of(int pat, int p, int v, int s);
        case (pat)
            0: return 7;
            1: return (p*5 + v*3 + s) % 8;
            2: return (v >= 2) ? 7 : 3;
            3: return 0;
            default: return (v == 3) ? 7 : ((v == 2) ? 0 : 3);
        endcase
    endfunction

    task automatic run_one(input int pat, input int m, input int d, input bit prio);
        int dir [3];
        int dor, best, bp, bv;
        bit home, stall;
        int ep, ev;
        string tag;
        @(negedge clk);
        for (int p = 0; p < 6; p++)
            for (int v = 0; v < 4; v++) begin
                crv[p][v] = cr_of(pat, p, v, m + d);
                credit_lvl[(p*4+v)*CW +: CW] = CW'(crv[p][v]);
            end
        node_x = W'(m); node_y = W'(m >> 2); node_z = W'(m >> 4);
        dest_x = W'(d); dest_y = W'(d >> 2); dest_z = W'(d >> 4);
        hdr_prio = prio;
        hdr_valid = 1'b1;
        // reference model from R2..R8
        dor = -1;
        for (int k = 0; k < 3; k++) begin
            int f;
            f = ((((d >> (2*k)) & 3) - ((m >> (2*k)) & 3)) % RING + RING) % RING;
            dir[k] = (f == 0) ? 0 : ((f <= RING/2) ? 1 : 2);
            if (dir[k] != 0 && dor < 0) dor = 2*k + ((dir[k] == 2) ? 1 : 0);
        end
        home = (dor < 0);
        stall = 1'b0; ep = 0; ev = 0;
        if (home) tag = "R3";
        else if (prio) begin
            tag = "R7";
            if (crv[dor][3] >= PKT) begin ep = dor; ev = 3; end else stall = 1'b1;
        end else begin
            best = -1; bp = 0; bv = 0;
            for (int k = 0; k < 3; k++)
                if (dir[k] != 0)
                    for (int v = 0; v < 2; v++) begin
                        int p;
                        p = 2*k + ((dir[k] == 2) ? 1 : 0);
                        if (crv[p][v] >= PKT && crv[p][v] > best) begin
                            best = crv[p][v]; bp = p; bv = v;
                        end
                    end
            if (best >= 0) begin
                ep = bp; ev = bv;
                tag = (pat == 0) ? "R2" : ((pat == 1) ? "R5" : "R4");
            end else if (crv[dor][2] >= PKT) begin
                ep = dor; ev = 2; tag = "R6";
            end else begin
                stall = 1'b1; tag = "R6";
            end
        end
        #1;
        if (stall) begin
            chk(hdr_ready == 1'b0, "R8 stall ready", int'(hdr_ready), 0);
            hdr_valid = 1'b0;
        end else begin
            chk(hdr_ready == 1'b1, {tag, " ready"}, int'(hdr_ready), 1);
            @(negedge clk);
            hdr_valid = 1'b0;
            chk(gnt_valid == 1'b1, "R9 grant valid", int'(gnt_valid), 1);
            chk(gnt_local == home, {tag, " local"}, int'(gnt_local), int'(home));
            chk(int'(gnt_port) == ep, {tag, " port"}, int'(gnt_port), ep);
            chk(int'(gnt_vc) == ev, {tag, " vc"}, int'(gnt_vc), ev);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(gnt_valid == 1'b0, "R1 reset grant", int'(gnt_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(gnt_valid == 1'b0, "R1 idle grant", int'(gnt_valid), 0);

        for (int pat = 0; pat < 5; pat++)
            for (int pr = 0; pr < 2; pr++)
                for (int m = 0; m < 64; m++)
                    for (int d = 0; d < 64; d++)
                        run_one(pat, m, d, pr[0]);

        // R10: backpressure on the grant stage
        @(negedge clk);
        gnt_ready = 1'b0;
        run_one(0, 0, 0, 1'b0);
        #1;
        chk(hdr_ready == 1'b0, "R10 ready blocked", int'(hdr_ready), 0);
        node_x = 2'd1;
        hdr_valid = 1'b1;
        @(negedge clk);
        hdr_valid = 1'b0;
        chk(gnt_valid == 1'b1, "R10 grant held", int'(gnt_valid), 1);
        chk(gnt_local == 1'b1, "R10 grant unchanged", int'(gnt_local), 1);
        gnt_ready = 1'b1;
        @(negedge clk);
        chk(gnt_valid == 1'b0, "R10 grant drained", int'(gnt_valid), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule